// File: doc/BRIEF.md
# 32-bit Integer Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for a 32-bit integer datapath. It takes two operands and a 4-bit operation code. It returns a 32-bit result, a carry flag and a signed-overflow flag in the same cycle. It is meant to sit in the execute stage of a simple load/store pipeline, with register-file reads and immediate extension handled outside it.

A single ripple adder serves six operations: signed and unsigned add, signed and unsigned subtract, and the two less-than compares. Subtraction inverts the second operand and forces the adder's carry-in high. The signed and unsigned forms of add and subtract give the same sum and carry. They differ only in whether the overflow flag may rise. The signed compare corrects the sign of the difference with the subtract overflow. The unsigned compare uses the inverted carry-out. Four bitwise operations share a separate logic slice.

Top module: `alu32_core`

## Requirements
- R1: With code 0000 (signed add), the result is the operands' sum modulo 2^32, and the carry flag is the carry out of bit 31.
- R2: With code 0010 (signed subtract), the result is A + ~B + 1 modulo 2^32, and the carry flag is that sum's carry out of bit 31, which is 1 exactly when A >= B unsigned.
- R3: For code 0000, the overflow flag is 1 exactly when both operands have the same sign bit and the result's sign bit differs. For code 0010, it is 1 exactly when the sign bits of A and B differ and the result's sign bit differs from A's.
- R4: The overflow flag is 0 for every code other than 0000 and 0010.
- R5: Codes 0001 (unsigned add) and 0011 (unsigned subtract) give the same result and carry as 0000 and 0010 respectively.
- R6: Codes 0100, 0101, 0110 and 0111 give A AND B, A OR B, A XOR B and NOT(A OR B) bit by bit, with the carry flag 0.
- R7: Code 1010 returns 1 when A < B as two's-complement numbers and 0 otherwise. This holds even when the subtraction overflows.
- R8: Code 1011 returns 1 when A < B as unsigned numbers and 0 otherwise.
- R9: For codes 1010 and 1011, result bits 31 to 1 are 0, and both flags are 0.
- R10: Every code not listed above (1000, 1001, 1100 to 1111) returns a zero result with both flags 0.
- R11: The outputs depend only on the current inputs. After any input change they settle within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| op_code | input | 4 | Operation select |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Adder carry out for add/subtract codes, else 0 |
| ovf_out | output | 1 | Signed overflow for codes 0000 and 0010, else 0 |

## Verification
Every result, including both flags, is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench drives new operands and a new code just after a rising edge of its sampling clock and compares on the following falling edge. This leaves half a period for the combinational paths to settle, and no check depends on the order of events at an edge. The expected values come from a behavioural model in the bench. That model uses widened arithmetic and built-in signed and unsigned comparison, not the adder's inversion trick.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_ADD  = 4'b0000,
    OP_ADDU = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_SUBU = 4'b0011,
    OP_AND  = 4'b0100,
    OP_OR   = 4'b0101,
    OP_XOR  = 4'b0110,
    OP_NOR  = 4'b0111,
    OP_SLT  = 4'b1010,
    OP_SLTU = 4'b1011
  } alu_op_e;

  // Signed overflow from the sign bits of the two adder inputs and the sum.
  function automatic logic sign_overflow(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  // Full-adder carry expressed with generate/propagate terms.
  function automatic logic carry_next(input logic g, input logic p, input logic c);
    return g | (p & c);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf_raw
);

  logic [W-1:0] b_eff;
  logic [W:0]   carry;

  assign carry[0] = subtract;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prop;
    logic gen;
    assign b_eff[i]     = b[i] ^ subtract;
    assign prop         = a[i] ^ b_eff[i];
    assign gen          = a[i] & b_eff[i];
    assign sum[i]       = prop ^ carry[i];
    assign carry[i+1]   = carry_next(gen, prop, carry[i]);
  end

  assign cout    = carry[W];
  assign ovf_raw = sign_overflow(a[W-1], b_eff[W-1], sum[W-1]);

  always_comb begin
    // R1
    carry_chain_chk: assert ({cout, sum} ==
                             ({1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, subtract}))
      else $error("ripple chain disagrees with wide sum");
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (sel)
      2'd0: y = a & b;
      2'd1: y = a | b;
      2'd2: y = a ^ b;
      default: y = ~(a | b);
    endcase
  end

  always_comb begin
    // R6
    nor_inverse_chk: assert (sel != 2'd3 || ((y & (a | b)) == '0))
      else $error("nor output overlaps operand ones");
  end

endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu_pkg::*;
(
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  input  logic [3:0]  op_code,
  output logic [31:0] result,
  output logic        carry_out,
  output logic        ovf_out
);

  localparam int unsigned W = DATA_W;

  alu_op_e      op;
  logic         do_sub;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_ovf;
  logic [W-1:0] logic_y;
  logic         lt_signed;
  logic         lt_unsigned;

  assign op     = alu_op_e'(op_code);
  assign do_sub = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);

  alu_addsub #(.W(W)) u_addsub (
    .a        (opnd_a),
    .b        (opnd_b),
    .subtract (do_sub),
    .sum      (add_sum),
    .cout     (add_cout),
    .ovf_raw  (add_ovf)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .a   (opnd_a),
    .b   (opnd_b),
    .sel (op_code[1:0]),
    .y   (logic_y)
  );

  // Difference sign corrected by overflow; unsigned borrow is inverted carry.
  assign lt_signed   = add_sum[W-1] ^ add_ovf;
  assign lt_unsigned = ~add_cout;

  always_comb begin
    result    = '0;
    carry_out = 1'b0;
    ovf_out   = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        result    = add_sum;
        carry_out = add_cout;
        ovf_out   = add_ovf;
      end
      OP_ADDU, OP_SUBU: begin
        result    = add_sum;
        carry_out = add_cout;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOR: result = logic_y;
      OP_SLT:  result = {{(W-1){1'b0}}, lt_signed};
      OP_SLTU: result = {{(W-1){1'b0}}, lt_unsigned};
      default: result = '0;
    endcase
  end

  always_comb begin
    // R4
    no_overflow_chk: assert (op == OP_ADD || op == OP_SUB || !ovf_out)
      else $error("overflow raised outside signed add/sub");
    // R9
    compare_upper_chk: assert (!(op == OP_SLT || op == OP_SLTU) ||
                               (result[W-1:1] == '0 && !carry_out && !ovf_out))
      else $error("compare result not a single bit");
    // R10
    unused_zero_chk: assert (op_code[3:2] == 2'b01 || op_code[3:2] == 2'b00 ||
                             op_code == 4'b1010 || op_code == 4'b1011 ||
                             (result == '0 && !carry_out && !ovf_out))
      else $error("unused code produced output");
    // R6
    logic_carry_chk: assert (op_code[3:2] != 2'b01 || (!carry_out && result == logic_y))
      else $error("logic code carry or result wrong");
    // R5
    unsigned_same_chk: assert (!(op == OP_ADDU || op == OP_SUBU) ||
                               (result == add_sum && carry_out == add_cout))
      else $error("unsigned add/sub differs from adder");
  end

endmodule

// File: tb/alu32_core_tb.sv
module alu32_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_in = '0;
  logic [31:0] b_in = '0;
  logic [3:0]  code_in = '0;
  logic [31:0] res_o;
  logic        c_o;
  logic        v_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu32_core dut_i (
    .opnd_a    (a_in),
    .opnd_b    (b_in),
    .op_code   (code_in),
    .result    (res_o),
    .carry_out (c_o),
    .ovf_out   (v_o)
  );

  // Vector: {code, a, b, expected result, expected carry, expected overflow}
  typedef logic [101:0] vec_t;
  localparam int NVEC = 17;
  localparam vec_t TBL [NVEC] = '{
    {4'b0000, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1},
    {4'b0000, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0},
    {4'b0001, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0},
    {4'b0010, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b1},
    {4'b0011, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b0},
    {4'b0010, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0},
    {4'b0100, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0},
    {4'b0101, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 1'b0, 1'b0},
    {4'b0110, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 1'b0, 1'b0},
    {4'b0111, 32'hF0F0F0F0, 32'hFF00FF00, 32'h000F000F, 1'b0, 1'b0},
    {4'b1010, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0},
    {4'b1010, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0},
    {4'b1011, 32'h00000001, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0},
    {4'b1011, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
    {4'b1011, 32'h00000005, 32'h00000005, 32'h00000000, 1'b0, 1'b0},
    {4'b1000, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
    {4'b1111, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0}
  };

  function automatic string req_tag(input logic [3:0] code);
    case (code)
      4'b0000: return "R1/R3";
      4'b0010: return "R2/R3";
      4'b0001, 4'b0011: return "R5/R4";
      4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R6/R4";
      4'b1010: return "R7/R9";
      4'b1011: return "R8/R9";
      default: return "R10";
    endcase
  endfunction

  // Behavioural model: returns {result, carry, overflow}
  function automatic logic [33:0] model(input logic [3:0] code, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [32:0] wide;
    logic [32:0] sx;
    case (code)
      4'b0000, 4'b0001: begin
        wide = {1'b0, a} + {1'b0, b};
        sx   = {a[31], a} + {b[31], b};
        return {wide[31:0], wide[32], (code == 4'b0000) && (sx[32] != sx[31])};
      end
      4'b0010, 4'b0011: begin
        wide = {1'b0, a} - {1'b0, b};
        sx   = {a[31], a} - {b[31], b};
        return {a - b, (a >= b), (code == 4'b0010) && (sx[32] != sx[31])};
      end
      4'b0100: return {a & b, 2'b00};
      4'b0101: return {a | b, 2'b00};
      4'b0110: return {a ^ b, 2'b00};
      4'b0111: return {~(a | b), 2'b00};
      4'b1010: return {31'd0, ($signed(a) < $signed(b)), 2'b00};
      4'b1011: return {31'd0, (a < b), 2'b00};
      default: return 34'd0;
    endcase
  endfunction

  task automatic apply_check(input logic [3:0] code, input logic [31:0] a,
                             input logic [31:0] b, input logic [33:0] exp,
                             input string tag);
    @(posedge clk);
    #1;
    code_in = code;
    a_in    = a;
    b_in    = b;
    @(negedge clk);
    checks++;
    if ({res_o, c_o, v_o} !== exp) begin
      fails++;
      $display("FAIL %s code=%b a=%h b=%h actual=%h/%b/%b expected=%h/%b/%b",
               tag, code, a, b, res_o, c_o, v_o, exp[33:2], exp[1], exp[0]);
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset state: zero operands with signed add give a zero result (R11, R1)
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply_check(4'b0000, 32'h0, 32'h0, 34'd0, "R11 reset");

    // Table walk: model-independent expected values
    for (int i = 0; i < NVEC; i++) begin
      apply_check(TBL[i][101:98], TBL[i][97:66], TBL[i][65:34],
                  TBL[i][33:0], req_tag(TBL[i][101:98]));
    end

    // Directed corners
    // R3: negative plus negative overflow
    apply_check(4'b0000, 32'h80000000, 32'h80000000, {32'h0, 1'b1, 1'b1}, "R3 neg+neg");
    // R3: subtract with differing signs, no overflow
    apply_check(4'b0010, 32'hFFFFFFFF, 32'h00000001, {32'hFFFFFFFE, 1'b1, 1'b0}, "R3 sub no ovf");
    // R4: unsigned subtract overflowing case keeps flag low
    apply_check(4'b0011, 32'h80000000, 32'h00000001, {32'h7FFFFFFF, 1'b1, 1'b0}, "R4 subu");
    // R7: -1 < 0 and 0 < min-negative false
    apply_check(4'b1010, 32'hFFFFFFFF, 32'h0, {32'h1, 2'b00}, "R7 -1<0");
    apply_check(4'b1010, 32'h0, 32'h80000000, {32'h0, 2'b00}, "R7 0<min");
    // R8: 0 < max unsigned
    apply_check(4'b1011, 32'h0, 32'hFFFFFFFF, {32'h1, 2'b00}, "R8 0<max");
    // R10: all remaining unused codes
    for (int c = 8; c < 16; c++) begin
      if (c != 10 && c != 11)
        apply_check(4'(c), 32'hDEADBEEF, 32'h12345678, 34'd0, "R10 unused");
    end

    // Random sweep over all codes, checked against the model
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  rc;
      logic [31:0] ra;
      logic [31:0] rb;
      rc = 4'($urandom_range(0, 15));
      ra = $urandom;
      rb = (i % 7 == 0) ? ra : $urandom;
      apply_check(rc, ra, rb, model(rc, ra, rb), req_tag(rc));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule